// File: doc/BRIEF.md
# Serial Shift Engine with Two-Wire Support

This block is the shift-and-count core behind a lightweight serial port on a small processor. One data register handles both directions at once: each shift event moves it one place toward the MSB, takes the incoming bit at the LSB, and presents the MSB on the outgoing line. An edge counter tracks progress through a byte. When the counter wraps, the block sets an overflow flag and copies the data register into a buffer register, so software can read the received byte later.

The shift clock comes from one of four sources: a software strobe, a timer pulse, or rising or falling edges of the external clock pin. In three-wire mode the outgoing bit drives a push-pull data pin. In two-wire mode the data and clock pins are open-drain. A start-condition detector runs in two-wire mode, and the block holds the clock line low while a start or overflow flag waits for service. The host reaches the block through a simple register port: write strobe, selector and data, plus four read buses.

Top module: `ushift_core`

## Requirements
- R1: After reset the data register, buffer, counter, both flags and the control register read 0. The clock-output level reads 1, and no output enable is active.
- R2: On each shift event the data register moves one place left and takes the synchronized input bit at bit 0. The input bit comes from `di_i` in three-wire mode and from `sda_i` in two-wire mode. A host write to the data register (`wr_sel`=0) in the same cycle takes precedence.
- R3: `do_o` copies the data register MSB only when the synchronized clock pin is low. While that clock is high, `do_o` holds its value.
- R4: The counter is `stat_o[3:0]`. In strobe and timer modes it advances on each shift event. In the two external modes it advances on both clock edges. When it moves from 15 to 0 it sets the overflow flag `stat_o[4]`, and `irq_ovf` = flag AND `ctrl_o[6]`.
- R5: The cycle the counter wraps, the buffer takes the value the data register holds after that cycle.
- R6: `ctrl_o[5:4]` selects the mode: 01 is three-wire, 10 is two-wire, 00 and 11 are off. `ctrl_o[3:2]` selects the clock source: 00 strobe, 01 `tmr_tick`, 10 external rising edge, 11 external falling edge. Shift events from a source that is not selected are ignored. `ctrl_o[1]` selects master, and `ctrl_o[0]` always reads 0.
- R7: In two-wire mode, a falling edge of the synchronized `sda_i` while the synchronized `sck_i` is high sets the start flag `stat_o[5]`. `irq_start` = flag AND `ctrl_o[7]`.
- R8: In two-wire mode `sda_oe` = NOT `do_o`, and `sck_oe` is active while either flag is set, or while in master role with the clock-output level at 0.
- R9: A status write (`wr_sel`=1) loads the counter from `wr_data[3:0]`. Writing 1 to bit 4 or bit 5 clears that flag. A flag set in the same cycle takes precedence over the clear.
- R10: A command write (`wr_sel`=3) with `wr_data[1]`=1 inverts the clock-output level. With `wr_data[0]`=1 it is the software strobe. In three-wire mode `sck_o` shows that level, `sck_oe` equals the master bit, and `do_oe` is 1.
- R11: With the mode off, no shift or count occurs, and `do_oe`, `sda_oe` and `sck_oe` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 2 | Write target: 0 data, 1 status, 2 control, 3 command |
| wr_data | input | DW | Host write data |
| data_o | output | DW | Data register |
| buf_o | output | DW | Buffer register |
| stat_o | output | CW+2 | Start flag, overflow flag, counter |
| ctrl_o | output | 8 | Control register |
| tmr_tick | input | 1 | Timer compare pulse |
| di_i | input | 1 | Three-wire data input pin |
| sda_i | input | 1 | Two-wire data pin level |
| sck_i | input | 1 | Clock pin level |
| do_o | output | 1 | Latched outgoing bit |
| do_oe | output | 1 | Push-pull data output enable |
| sda_oe | output | 1 | Open-drain data pull-low |
| sck_o | output | 1 | Clock output level |
| sck_oe | output | 1 | Clock output enable / pull-low |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_start | output | 1 | Start-condition interrupt request |

## Verification
The bench builds the block with DW=8 and SYNC=2. With these values a full byte takes 16 counted edges, and the pin-to-effect latency is two cycles, so a wrap, a buffer copy and a start detection can all be reached within a few dozen cycles. A behavioural model follows the same two-cycle pin delay and checks every output on every clock. Directed sequences cover each clock source, both modes, latch holding and flag clearing. A long randomized phase then covers simultaneous writes and shifts, reserved modes and counter wraps.

// File: rtl/ushift_core.sv
module ushift_core #(
  parameter int DW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] data_o,
  output logic [DW-1:0] buf_o,
  output logic [$clog2(2*DW)+1:0] stat_o,
  output logic [7:0]    ctrl_o,
  input  logic          tmr_tick,
  input  logic          di_i,
  input  logic          sda_i,
  input  logic          sck_i,
  output logic          do_o,
  output logic          do_oe,
  output logic          sda_oe,
  output logic          sck_o,
  output logic          sck_oe,
  output logic          irq_ovf,
  output logic          irq_start
);
  localparam int CW = $clog2(2*DW);
  localparam logic [CW-1:0] CMAX = '1;

  logic [SYNC-1:0] sck_sy, sda_sy, di_sy;
  logic sck_p, sda_p;
  logic [DW-1:0] dr_q, buf_q, dr_nxt;
  logic [CW-1:0] cnt_q;
  logic [7:0] ctrl_q;
  logic ovf_q, st_q, clk_q, do_q;

  wire sck_s = sck_sy[SYNC-1];
  wire sda_s = sda_sy[SYNC-1];
  wire di_s  = di_sy[SYNC-1];

  wire d_wr = wr_en && wr_sel == 2'd0;
  wire s_wr = wr_en && wr_sel == 2'd1;
  wire c_wr = wr_en && wr_sel == 2'd2;
  wire k_wr = wr_en && wr_sel == 2'd3;

  wire on3 = ctrl_q[5:4] == 2'b01;
  wire on2 = ctrl_q[5:4] == 2'b10;
  wire on  = on3 | on2;
  wire master = ctrl_q[1];
  wire rise = sck_s & ~sck_p;
  wire fall = ~sck_s & sck_p;
  wire din  = on2 ? sda_s : di_s;

  logic shift_ev, cnt_ev;
  always_comb begin
    case (ctrl_q[3:2])
      2'b00:   shift_ev = k_wr & wr_data[0];
      2'b01:   shift_ev = tmr_tick;
      2'b10:   shift_ev = rise;
      default: shift_ev = fall;
    endcase
    shift_ev = shift_ev & on;
    cnt_ev   = ctrl_q[3] ? (on & (rise | fall)) : shift_ev;
  end

  always_comb begin
    dr_nxt = dr_q;
    if (d_wr)          dr_nxt = wr_data;
    else if (shift_ev) dr_nxt = {dr_q[DW-2:0], din};
  end

  wire ovf_hit   = cnt_ev && !s_wr && cnt_q == CMAX;
  wire start_det = on2 && sck_s && sda_p && !sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy <= '1;
      sda_sy <= '1;
      di_sy  <= '0;
      sck_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      sck_sy <= {sck_sy[SYNC-2:0], sck_i};
      sda_sy <= {sda_sy[SYNC-2:0], sda_i};
      di_sy  <= {di_sy[SYNC-2:0], di_i};
      sck_p  <= sck_s;
      sda_p  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr_q   <= '0;
      buf_q  <= '0;
      cnt_q  <= '0;
      ctrl_q <= '0;
      ovf_q  <= 1'b0;
      st_q   <= 1'b0;
      clk_q  <= 1'b1;
      do_q   <= 1'b0;
    end else begin
      dr_q <= dr_nxt;
      if (ovf_hit) buf_q <= dr_nxt;
      if (s_wr)        cnt_q <= wr_data[CW-1:0];
      else if (cnt_ev) cnt_q <= cnt_q + 1'b1;
      if (ovf_hit)                 ovf_q <= 1'b1;
      else if (s_wr && wr_data[CW]) ovf_q <= 1'b0;
      if (start_det)                  st_q <= 1'b1;
      else if (s_wr && wr_data[CW+1]) st_q <= 1'b0;
      if (c_wr) ctrl_q <= {wr_data[7:1], 1'b0};
      if (k_wr && wr_data[1]) clk_q <= ~clk_q;
      if (!sck_s) do_q <= dr_q[DW-1];
    end
  end

  assign data_o    = dr_q;
  assign buf_o     = buf_q;
  assign stat_o    = {st_q, ovf_q, cnt_q};
  assign ctrl_o    = ctrl_q;
  assign do_o      = do_q;
  assign do_oe     = on3;
  assign sda_oe    = on2 & ~do_q;
  assign sck_o     = on2 ? 1'b0 : clk_q;
  assign sck_oe    = on3 ? master : (on2 & ((master & ~clk_q) | st_q | ovf_q));
  assign irq_ovf   = ovf_q & ctrl_q[6];
  assign irq_start = st_q & ctrl_q[7];

  a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_ev && !d_wr) |=> (dr_q[0] == $past(din)));

  a_r3_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sck_s) |-> $stable(do_q));

  a_r4_wrap_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_ev && !s_wr && cnt_q == CMAX) |=> (ovf_q && cnt_q == '0));

  a_r5_buf_copy: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_hit |=> (buf_q == dr_q));

  a_r7_start_flag: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> st_q);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!on && !d_wr) |=> $stable(dr_q));
endmodule

// File: tb/sim_ushift_core.sv
module sim_ushift_core;
  localparam int DW = 8;
  localparam int SYNC = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic tmr_tick = 1'b0, di_i = 1'b0, sda_i = 1'b1, sck_i = 1'b1;
  logic [7:0] data_o, buf_o, ctrl_o;
  logic [5:0] stat_o;
  logic do_o, do_oe, sda_oe, sck_o, sck_oe, irq_ovf, irq_start;

  int tests = 0, fails = 0;
  bit run_cmp = 1'b0;

  always #4 clk = ~clk;

  ushift_core #(.DW(DW), .SYNC(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .data_o(data_o), .buf_o(buf_o), .stat_o(stat_o), .ctrl_o(ctrl_o),
    .tmr_tick(tmr_tick), .di_i(di_i), .sda_i(sda_i), .sck_i(sck_i),
    .do_o(do_o), .do_oe(do_oe), .sda_oe(sda_oe), .sck_o(sck_o), .sck_oe(sck_oe),
    .irq_ovf(irq_ovf), .irq_start(irq_start));

  // behavioural reference model
  logic [7:0] m_dr, m_buf, m_ctrl, nd;
  int m_cnt;
  bit m_ovf, m_st, m_clk, m_do, m_sckp, m_sdap;
  bit s_sck, s_sda, s_di, on2, on3, sh, ct, hit, rise, fall, din, strobe;
  bit sq[$], aq[$], dq[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dr = 0; m_buf = 0; m_ctrl = 0; m_cnt = 0;
      m_ovf = 0; m_st = 0; m_clk = 1; m_do = 0; m_sckp = 1; m_sdap = 1;
      sq = {}; aq = {}; dq = {};
      for (int i = 0; i < SYNC; i++) begin sq.push_back(1); aq.push_back(1); dq.push_back(0); end
    end else begin
      s_sck = sq[0]; s_sda = aq[0]; s_di = dq[0];
      on3 = m_ctrl[5:4] == 2'b01;
      on2 = m_ctrl[5:4] == 2'b10;
      rise = s_sck && !m_sckp;
      fall = !s_sck && m_sckp;
      strobe = wr_en && wr_sel == 3 && wr_data[0];
      case (m_ctrl[3:2])
        0: sh = strobe;
        1: sh = tmr_tick;
        2: sh = rise;
        default: sh = fall;
      endcase
      sh = sh && (on2 || on3);
      ct = m_ctrl[3] ? ((on2 || on3) && (rise || fall)) : sh;
      din = on2 ? s_sda : s_di;
      if (wr_en && wr_sel == 0) nd = wr_data;
      else if (sh) nd = {m_dr[6:0], din};
      else nd = m_dr;
      hit = ct && !(wr_en && wr_sel == 1) && m_cnt == 15;
      if (!s_sck) m_do = m_dr[7];
      if (hit) m_buf = nd;
      if (wr_en && wr_sel == 1) m_cnt = wr_data[3:0];
      else if (ct) m_cnt = (m_cnt + 1) % 16;
      if (hit) m_ovf = 1; else if (wr_en && wr_sel == 1 && wr_data[4]) m_ovf = 0;
      if (on2 && s_sck && m_sdap && !s_sda) m_st = 1;
      else if (wr_en && wr_sel == 1 && wr_data[5]) m_st = 0;
      if (wr_en && wr_sel == 2) m_ctrl = wr_data & 8'hFE;
      if (wr_en && wr_sel == 3 && wr_data[1]) m_clk = !m_clk;
      m_dr = nd;
      m_sckp = s_sck; m_sdap = s_sda;
      sq.push_back(sck_i); void'(sq.pop_front());
      aq.push_back(sda_i); void'(aq.pop_front());
      dq.push_back(di_i);  void'(dq.pop_front());
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #3;
    if (run_cmp && rst_n) begin
      bit e3, e2;
      e3 = m_ctrl[5:4] == 2'b01;
      e2 = m_ctrl[5:4] == 2'b10;
      chk("R2 data", data_o, m_dr);
      chk("R5 buffer", buf_o, m_buf);
      chk("R4/R9 status", stat_o, {m_st, m_ovf, m_cnt[3:0]});
      chk("R6 control", ctrl_o, m_ctrl);
      chk("R3 do", do_o, m_do);
      chk("R10 do_oe", do_oe, e3);
      chk("R8 sda_oe", sda_oe, e2 && !m_do);
      chk("R10 sck_o", sck_o, e2 ? 0 : m_clk);
      chk("R8 sck_oe", sck_oe, e3 ? m_ctrl[1] : (e2 && ((m_ctrl[1] && !m_clk) || m_st || m_ovf)));
      chk("R4 irq_ovf", irq_ovf, m_ovf && m_ctrl[6]);
      chk("R7 irq_start", irq_start, m_st && m_ctrl[7]);
    end
  end

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1; run_cmp = 1; idle(1);
    // R1 reset state
    chk("R1 data", data_o, 0); chk("R1 stat", stat_o, 0);
    chk("R1 sck_o", sck_o, 1);
    chk("R1 oe", {do_oe, sda_oe, sck_oe}, 0);
    // strobe mode, three-wire master
    di_i = 1;
    wr(2, 8'h52); wr(0, 8'hA5); idle(2);
    wr(3, 8'h01); idle(1);
    chk("R2 strobe shift", data_o, 8'h4B); chk("R4 count", stat_o, 6'h01);
    wr(1, 8'h0F); wr(3, 8'h01); idle(1);
    chk("R2 second shift", data_o, 8'h97);
    chk("R4 wrap flag", stat_o, 6'h10); chk("R5 buffer copy", buf_o, 8'h97);
    chk("R4 irq_ovf", irq_ovf, 1);
    wr(1, 8'h10); idle(1);
    chk("R9 ovf clear", stat_o, 6'h00); chk("R9 irq off", irq_ovf, 0);
    // R10 toggle, R3 latch
    wr(3, 8'h02); idle(1);
    chk("R10 toggle", sck_o, 0); chk("R10 master oe", sck_oe, 1);
    sck_i = 0; idle(4); chk("R3 transparent", do_o, 1);
    sck_i = 1; idle(4); wr(0, 8'h00); idle(3);
    chk("R3 hold while high", do_o, 1);
    sck_i = 0; idle(4); chk("R3 follows when low", do_o, 0);
    sck_i = 1; idle(4);
    // R6 timer source
    wr(2, 8'h56); wr(0, 8'h00); idle(2);
    @(negedge clk); tmr_tick = 1; @(negedge clk); tmr_tick = 0; idle(1);
    chk("R6 timer shift", data_o, 8'h01);
    wr(2, 8'h52);
    @(negedge clk); tmr_tick = 1; @(negedge clk); tmr_tick = 0; idle(1);
    chk("R6 timer ignored", data_o, 8'h01);
    // R4 external rising, both edges counted
    wr(2, 8'h5A); wr(1, 8'h10); wr(0, 8'h00); idle(2);
    sck_i = 0; idle(4); sck_i = 1; idle(4);
    chk("R2 ext rising shift", data_o, 8'h01); chk("R4 both edges", stat_o, 6'h02);
    // R7/R8 two-wire start condition
    wr(2, 8'hA8); idle(3);
    sda_i = 0; idle(4);
    chk("R7 start flag", stat_o, 6'h22); chk("R7 irq_start", irq_start, 1);
    chk("R8 clock hold", sck_oe, 1);
    wr(1, 8'h20); idle(1);
    chk("R9 start clear", stat_o, 6'h00); chk("R8 hold released", sck_oe, 0);
    sda_i = 1; idle(4);
    // R11 mode off
    wr(2, 8'h00); wr(0, 8'h3C); wr(3, 8'h01); idle(1);
    chk("R11 no shift", data_o, 8'h3C);
    chk("R11 no drive", {do_oe, sda_oe, sck_oe}, 0);
    // randomized phase, model compared every cycle
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      tmr_tick = ($urandom % 7) == 0;
      if ($urandom % 3 == 0) sck_i = ~sck_i;
      if ($urandom % 4 == 0) sda_i = ~sda_i;
      di_i = $urandom;
      wr_en = ($urandom % 5) == 0;
      wr_sel = $urandom;
      wr_data = $urandom;
      if (wr_sel == 2 && ($urandom % 4) != 0) wr_en = 0;
      if (wr_sel == 2 && wr_en) wr_data[5:4] = 2'($urandom % 3 + 1);
    end
    @(negedge clk); wr_en = 0; idle(4);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule